// File: doc/BRIEF.md
# Predicated Vector XOR Fold Unit

This unit collapses one wide vector operand into a single element by combining every active lane with exclusive OR. At run time a two-bit width code splits the vector into bytes, halfwords, words or doublewords. A per-byte predicate says which lanes take part. The folded element comes back on a 64-bit scalar port, and every bit above the element width is zero.

A small decoder reads the 32-bit instruction word that arrives with the operands. It checks the fixed opcode bits and pulls out the width code, the governing predicate index, the source vector index and the destination index. The two operand indices are presented combinationally, so the surrounding datapath can fetch the operands. The destination index travels down the pipeline alongside the result. Operands enter through a valid/ready handshake. The result leaves through a second valid/ready pair.

The fold is a balanced tree with a register after every level. The number of cycles from acceptance to result therefore depends only on the vector length parameter. It does not depend on the width code, the data or the predicate.

Top module: `vxor_fold`

## Requirements
- R1: Width code 0, 1, 2 and 3 (instruction bits 23:22) select elements of 8, 16, 32 and 64 bits. The vector holds VL divided by that width elements.
- R2: The result starts from zero and takes the XOR of every active element. With a full predicate it is the XOR of all elements.
- R3: Element e is active when the predicate bit at byte position e·(width/8) is 1. For wider elements, every other predicate bit in the element's byte group has no effect on the result.
- R4: A predicate of all zeros gives a result of zero for every width code.
- R5: Result bits at and above the element width are zero.
- R6: The instruction word carries the governing predicate index in bits 12:10, the source index in bits 9:5 and the destination index in bits 4:0. The first two appear combinationally on `in_pg_idx` and `in_src_idx`. The destination index comes back on `out_dest` together with its result.
- R7: A word whose fixed fields differ from bits 31:24 = 00000100, bits 21:16 = 011001 and bits 15:13 = 001 is reported with `out_undef` = 1 and a result of zero.
- R8: While `out_ready` is held at 1, a result appears exactly LAT = clog2(VL/64)+2 cycles after its operands were accepted. For the default VL of 256 that is 4 cycles, for every width code and data value.
- R9: `in_ready` equals (!`out_valid` || `out_ready`). A result that is held back by `out_ready` = 0 stays stable. Results leave in the order their operands were accepted.
- R10: During and right after a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and instruction word are present |
| in_ready | output | 1 | Unit accepts operands this cycle |
| in_insn | input | 32 | Instruction word |
| in_vec | input | VL | Source vector |
| in_pred | input | VL/8 | Predicate, one bit per vector byte |
| in_pg_idx | output | 3 | Decoded governing predicate index |
| in_src_idx | output | 5 | Decoded source vector index |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Folded element, zero-extended |
| out_dest | output | 5 | Destination index of this result |
| out_undef | output | 1 | Instruction word did not decode |

## Verification
The assertions check four things on every cycle. A stalled result holds steady, `in_ready` is high whenever the output is empty, an undecodable word never carries a non-zero result, and the bits above the active element width stay clear. The bench's scenarios are the only way to show the arithmetic. That covers the fold value for each width, the choice of governing predicate bit, the zero result for an empty predicate, and the exact latency under a free-running consumer. The bench also shows that results keep their order across random backpressure. Each of these checks compares against a behavioural reference model.

// File: rtl/vxor_fold_pkg.sv
// Package: shared types and elaboration helpers for the XOR fold unit.
// Assumes callers pass a positive word count to the tree helpers.
package vxor_fold_pkg;

    // Sideband that travels with each transaction through the pipeline
    typedef struct packed {
        logic       valid;
        logic       undef;
        logic [1:0] size;
        logic [4:0] dest;
    } side_t;

    localparam logic [7:0] OPC_TOP = 8'b0000_0100;
    localparam logic [5:0] OPC_MID = 6'b01_1001;
    localparam logic [2:0] OPC_LOW = 3'b001;

    // Nodes held in tree level l when nw leaf words enter
    function automatic int lvl_cnt(input int nw, input int l);
        return (nw + (1 << (l + 1)) - 1) >> (l + 1);
    endfunction

    // Flat offset of the first node of level l
    function automatic int lvl_base(input int nw, input int l);
        int s;
        s = 0;
        for (int k = 0; k < l; k++) s += lvl_cnt(nw, k);
        return s;
    endfunction

    // Count of inputs feeding level l
    function automatic int prev_cnt(input int nw, input int l);
        return (l == 0) ? nw : lvl_cnt(nw, l - 1);
    endfunction

    // Offset of level l's inputs in the combined leaf+node array
    function automatic int src_base(input int nw, input int l);
        return (l == 0) ? 0 : nw + lvl_base(nw, l - 1);
    endfunction

endpackage

// File: rtl/vxor_fold_dec.sv
// Decoder: splits the 32-bit instruction word into fields and flags
// any word whose fixed opcode bits do not match. Purely combinational.
module vxor_fold_dec
    import vxor_fold_pkg::*;
(
    input  logic [31:0] insn,
    output logic [1:0]  size,
    output logic [2:0]  pg,
    output logic [4:0]  zn,
    output logic [4:0]  vd,
    output logic        undef
);

    // Field extraction and opcode match
    always_comb begin
        size  = insn[23:22];
        pg    = insn[12:10];
        zn    = insn[9:5];
        vd    = insn[4:0];
        undef = (insn[31:24] != OPC_TOP) ||
                (insn[21:16] != OPC_MID) ||
                (insn[15:13] != OPC_LOW);
    end

endmodule

// File: rtl/vxor_fold_mask.sv
// Lane mask: zeroes every byte of an inactive element. Each byte takes
// the predicate bit at the lowest byte of the element it belongs to.
// Assumes VL is a multiple of 64 so every element width divides it.
module vxor_fold_mask #(
    parameter int VL = 256,
    localparam int NB = VL / 8
) (
    input  logic [VL-1:0] vec,
    input  logic [NB-1:0] pred,
    input  logic [1:0]    size,
    output logic [VL-1:0] masked
);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic act;

        // Pick the governing predicate bit for this byte's element
        always_comb begin
            case (size)
                2'd0:    act = pred[b];
                2'd1:    act = pred[(b / 2) * 2];
                2'd2:    act = pred[(b / 4) * 4];
                default: act = pred[(b / 8) * 8];
            endcase
        end

        assign masked[8*b +: 8] = act ? vec[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/vxor_fold_tree.sv
// Balanced XOR tree over 64-bit words with a register after every
// level; an odd node is passed through. Depth is clog2(NW) cycles.
// Assumes NW >= 2; data registers are not reset (valid travels apart).
module vxor_fold_tree
    import vxor_fold_pkg::*;
#(
    parameter int NW = 4,
    parameter int W  = 64,
    localparam int LEVELS = $clog2(NW),
    localparam int TOTAL  = lvl_base(NW, LEVELS),
    localparam int MAXC   = (NW + 1) / 2
) (
    input  logic            clk,
    input  logic            en,
    input  logic [NW*W-1:0] words,
    output logic [W-1:0]    folded
);

    logic [W-1:0] node_q [TOTAL];
    logic [W-1:0] all_w  [NW + TOTAL];

    // Combined view of leaf words followed by registered nodes
    always_comb begin
        for (int k = 0; k < NW; k++) all_w[k] = words[W*k +: W];
        for (int k = 0; k < TOTAL; k++) all_w[NW + k] = node_q[k];
    end

    // Advance every level of the tree by one stage when enabled
    always_ff @(posedge clk) begin
        if (en) begin
            for (int l = 0; l < LEVELS; l++) begin
                for (int i = 0; i < MAXC; i++) begin
                    if (i < lvl_cnt(NW, l)) begin
                        if (2 * i + 1 < prev_cnt(NW, l))
                            node_q[lvl_base(NW, l) + i] <=
                                all_w[src_base(NW, l) + 2 * i] ^
                                all_w[src_base(NW, l) + 2 * i + 1];
                        else
                            node_q[lvl_base(NW, l) + i] <=
                                all_w[src_base(NW, l) + 2 * i];
                    end
                end
            end
        end
    end

    assign folded = all_w[NW + TOTAL - 1];

endmodule

// File: rtl/vxor_fold_narrow.sv
// Narrowing fold: halves a 64-bit XOR word down to the element width
// and zero-extends. Valid because elements are naturally aligned.
module vxor_fold_narrow (
    input  logic [63:0] word,
    input  logic [1:0]  size,
    output logic [63:0] result
);

    logic [31:0] f32;
    logic [15:0] f16;
    logic [7:0]  f8;

    // Successive half folds
    always_comb begin
        f32 = word[31:0] ^ word[63:32];
        f16 = f32[15:0] ^ f32[31:16];
        f8  = f16[7:0] ^ f16[15:8];
    end

    // Select the fold matching the element width
    always_comb begin
        case (size)
            2'd0:    result = {56'd0, f8};
            2'd1:    result = {48'd0, f16};
            2'd2:    result = {32'd0, f32};
            default: result = word;
        endcase
    end

endmodule

// File: rtl/vxor_fold.sv
// Top: predicated XOR fold of a VL-bit vector to one element.
// Stage 0 masks lanes, LEVELS stages fold words, last stage narrows.
// The whole pipeline stalls together on output backpressure.
// Assumes VL is a multiple of 128 in the range 128..2048.
module vxor_fold
    import vxor_fold_pkg::*;
#(
    parameter int VL = 256,
    localparam int NB     = VL / 8,
    localparam int NW     = VL / 64,
    localparam int LEVELS = $clog2(NW),
    localparam int LAT    = LEVELS + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_insn,
    input  logic [VL-1:0] in_vec,
    input  logic [NB-1:0] in_pred,
    output logic [2:0]    in_pg_idx,
    output logic [4:0]    in_src_idx,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [63:0]   out_result,
    output logic [4:0]    out_dest,
    output logic          out_undef
);

    logic          adv;
    logic [1:0]    d_size;
    logic [4:0]    d_vd;
    logic          d_undef;
    logic [VL-1:0] m_vec;
    logic [VL-1:0] s0_vec_q;
    logic [63:0]   t_word;
    logic [63:0]   n_res;
    logic [63:0]   res_q;
    side_t         side_q [LAT];

    // Pipeline moves whenever the output slot is free or being taken
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    vxor_fold_dec u_dec (
        .insn  (in_insn),
        .size  (d_size),
        .pg    (in_pg_idx),
        .zn    (in_src_idx),
        .vd    (d_vd),
        .undef (d_undef)
    );

    vxor_fold_mask #(.VL(VL)) u_mask (
        .vec    (in_vec),
        .pred   (in_pred),
        .size   (d_size),
        .masked (m_vec)
    );

    // Stage 0: capture the masked vector
    always_ff @(posedge clk) begin
        if (adv) s0_vec_q <= m_vec;
    end

    // Sideband shift register aligned with the datapath stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) side_q[i] <= '0;
        end else if (adv) begin
            side_q[0] <= {in_valid, d_undef, d_size, d_vd};
            for (int i = 1; i < LAT; i++) side_q[i] <= side_q[i-1];
        end
    end

    vxor_fold_tree #(.NW(NW), .W(64)) u_tree (
        .clk    (clk),
        .en     (adv),
        .words  (s0_vec_q),
        .folded (t_word)
    );

    vxor_fold_narrow u_narrow (
        .word   (t_word),
        .size   (side_q[LAT-2].size),
        .result (n_res)
    );

    // Output stage: narrowed result, suppressed for undecodable words
    always_ff @(posedge clk) begin
        if (!rst_n)   res_q <= '0;
        else if (adv) res_q <= side_q[LAT-2].undef ? 64'd0 : n_res;
    end

    assign out_valid  = side_q[LAT-1].valid;
    assign out_undef  = side_q[LAT-1].undef;
    assign out_dest   = side_q[LAT-1].dest;
    assign out_result = res_q;

endmodule

// File: rtl/vxor_fold_chk.sv
// Checker: cycle-level properties of the fold unit's output port.
// Attached to every vxor_fold instance by the bind below.
module vxor_fold_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_undef,
    input logic [63:0] out_result,
    input logic [4:0]  out_dest,
    input logic [1:0]  out_sz
);

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) &&
        $stable(out_dest) && $stable(out_undef));

    // R9
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R7
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_undef |-> out_result == 64'd0);

    // R5
    zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result >> (7'd8 << out_sz)) == 64'd0);

endmodule

bind vxor_fold vxor_fold_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_undef  (out_undef),
    .out_result (out_result),
    .out_dest   (out_dest),
    .out_sz     (side_q[LAT-1].size)
);

// File: tb/vxor_fold_tb.sv
module vxor_fold_tb;
    localparam int VL  = 256;
    localparam int PW  = VL / 8;
    localparam int LAT = $clog2(VL / 64) + 2;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0;
    logic          in_ready;
    logic [31:0]   in_insn = '0;
    logic [VL-1:0] in_vec = '0;
    logic [PW-1:0] in_pred = '0;
    logic [2:0]    in_pg_idx;
    logic [4:0]    in_src_idx;
    logic          out_valid;
    logic          out_ready = 1;
    logic [63:0]   out_result;
    logic [4:0]    out_dest;
    logic          out_undef;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit bp_on = 0, lat_on = 1, head_seen = 0, done = 0;

    logic [63:0] q_res[$];
    logic [4:0]  q_dst[$];
    logic        q_und[$];
    logic [1:0]  q_sz[$];
    int          q_cyc[$];
    bit          q_lat[$];
    string       q_tag[$];
    string       cur_tag = "R2";

    vxor_fold #(.VL(VL)) u_dut (.*);

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] pg,
                                       input logic [4:0] zn, input logic [4:0] vd);
        return {8'b0000_0100, sz, 6'b01_1001, 3'b001, pg, zn, vd};
    endfunction

    function automatic logic [VL-1:0] rvec();
        logic [VL-1:0] v;
        for (int k = 0; k < VL / 32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [PW-1:0] rpred();
        logic [PW-1:0] p;
        p = $urandom;
        return p;
    endfunction

    // Behavioural reference: walk elements, gate by lowest-byte predicate bit
    function automatic logic [63:0] ref_fold(input logic [31:0] w,
                                             input logic [VL-1:0] v,
                                             input logic [PW-1:0] p);
        logic [63:0] acc;
        int es;
        acc = '0;
        if (w[31:24] != 8'h04 || w[21:16] != 6'b011001 || w[15:13] != 3'b001)
            return '0;
        es = 8 << w[23:22];
        for (int e = 0; e < VL / es; e++)
            if (p[e * (es / 8)])
                for (int b = 0; b < es; b++) acc[b] = acc[b] ^ v[e * es + b];
        return acc;
    endfunction

    function automatic bit is_undef(input logic [31:0] w);
        return w[31:24] != 8'h04 || w[21:16] != 6'b011001 || w[15:13] != 3'b001;
    endfunction

    // Monitor: compares against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            check(in_ready == (!out_valid || out_ready), "R9 ready",
                  {63'd0, in_ready}, {63'd0, !out_valid || out_ready});
            if (out_valid) begin
                if (q_res.size() == 0) begin
                    check(0, "R9 unexpected output", out_result, 64'd0);
                end else begin
                    check(out_result == q_res[0], q_tag[0], out_result, q_res[0]);
                    check(out_dest == q_dst[0], "R6 dest", {59'd0, out_dest}, {59'd0, q_dst[0]});
                    check(out_undef == q_und[0], "R7 undef", {63'd0, out_undef}, {63'd0, q_und[0]});
                    if (!q_und[0])
                        check((out_result >> (8 << q_sz[0])) == 0 || q_sz[0] == 3,
                              "R5 zero-ext", out_result, q_res[0]);
                    if (!head_seen && q_lat[0])
                        check(cyc - q_cyc[0] == LAT, "R8 latency",
                              64'(cyc - q_cyc[0]), 64'(LAT));
                    head_seen = 1;
                    if (out_ready) begin
                        void'(q_res.pop_front()); void'(q_dst.pop_front());
                        void'(q_und.pop_front()); void'(q_sz.pop_front());
                        void'(q_cyc.pop_front()); void'(q_lat.pop_front());
                        void'(q_tag.pop_front());
                        head_seen = 0;
                    end
                end
            end else if (q_res.size() != 0 && q_lat[0] && cyc - q_cyc[0] > LAT) begin
                check(0, "R8 overdue", 64'(cyc - q_cyc[0]), 64'(LAT));
            end
            if (in_valid && in_ready) begin
                check(in_pg_idx == in_insn[12:10] && in_src_idx == in_insn[9:5], "R6 fields",
                      {56'd0, in_pg_idx, in_src_idx}, {56'd0, in_insn[12:10], in_insn[9:5]});
                q_res.push_back(ref_fold(in_insn, in_vec, in_pred));
                q_dst.push_back(in_insn[4:0]);
                q_und.push_back(is_undef(in_insn));
                q_sz.push_back(in_insn[23:22]);
                q_cyc.push_back(cyc);
                q_lat.push_back(lat_on);
                q_tag.push_back(cur_tag);
            end
        end
    end

    // Random output backpressure in the stall phase
    always @(posedge clk) begin
        #2;
        if (bp_on) out_ready = ($urandom % 3) != 0;
    end

    task automatic send(input string tag, input logic [31:0] w,
                        input logic [VL-1:0] v, input logic [PW-1:0] p);
        cur_tag = tag; in_insn = w; in_vec = v; in_pred = p; in_valid = 1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #2;
        in_valid = 0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (q_res.size() != 0 && guard < 2000) begin
            @(posedge clk); #2; guard++;
        end
        repeat (3) @(posedge clk);
        #2;
        check(q_res.size() == 0, "R9 drained", 64'(q_res.size()), 64'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [PW-1:0] p;
        logic [31:0]   w;
        repeat (5) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check(!out_valid, "R10 out_valid", {63'd0, out_valid}, 64'd0);
        check(in_ready, "R10 in_ready", {63'd0, in_ready}, 64'd1);
        @(posedge clk); #2;

        // R1 / R2: each width with a full predicate
        for (int s = 0; s < 4; s++) send("R1", mk(2'(s), 3'd1, 5'd2, 5'(s)), rvec(), '1);
        for (int s = 0; s < 4; s++) send("R2", mk(2'(s), 3'd0, 5'd9, 5'd7), rvec(), rpred());
        // R4: empty predicate
        for (int s = 0; s < 4; s++) send("R4", mk(2'(s), 3'd3, 5'd4, 5'd1), rvec(), '0);
        // R3: only non-governing predicate bits set
        send("R3", mk(2'd1, 3'd2, 5'd3, 5'd5), rvec(), {(PW/2){2'b10}});
        send("R3", mk(2'd2, 3'd2, 5'd3, 5'd5), rvec(), {(PW/4){4'b1110}});
        send("R3", mk(2'd3, 3'd2, 5'd3, 5'd5), rvec(), {(PW/8){8'hFE}});
        p = '0; p[12] = 1'b1;
        send("R3", mk(2'd2, 3'd7, 5'd31, 5'd31), rvec(), p);
        p = '0; p[8] = 1'b1; p[9] = 1'b1;
        send("R3", mk(2'd3, 3'd5, 5'd17, 5'd0), rvec(), p);
        // R7: corrupt each fixed field
        send("R7", mk(2'd0, 3'd1, 5'd1, 5'd1) ^ 32'h8000_0000, rvec(), '1);
        send("R7", mk(2'd2, 3'd1, 5'd1, 5'd1) ^ 32'h0010_0000, rvec(), '1);
        send("R7", mk(2'd3, 3'd1, 5'd1, 5'd1) ^ 32'h0000_4000, rvec(), '1);
        // R8: back-to-back random mix at full rate
        for (int k = 0; k < 40; k++) begin
            w = mk(2'($urandom), 3'($urandom), 5'($urandom), 5'($urandom));
            if ($urandom % 8 == 0) w = w ^ (32'd1 << (13 + $urandom % 19));
            send("R8", w, rvec(), rpred());
        end
        drain();

        // R9: random backpressure, order and stability
        lat_on = 0; bp_on = 1;
        for (int k = 0; k < 60; k++)
            send("R9", mk(2'($urandom), 3'($urandom), 5'($urandom), 5'($urandom)),
                 rvec(), rpred());
        bp_on = 0; out_ready = 1;
        drain();

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cyc=%0d", cyc);
        done = 1;
        summary();
        $finish;
    end

endmodule